// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the host-side master for a 16-bit-word serial EEPROM reached over three wires: chip select, serial clock and serial data out of the host, plus one serial data line back from the memory. Software-side logic hands it one command at a time on a valid/ready request port: an operation code, a word address, write data and, for reads, a word count. The controller builds the serial frame, drives the pins, and reports completion with a one-cycle `done` pulse and a `timed_out` flag.

Every instruction occupies a fixed 16-clock command frame. Leading zero bits pad the frame in front of the start bit, so host firmware sees the same frame length whatever the address width. A program command (write, erase, fill or clear) is launched by dropping chip select after its last bit. The controller then raises chip select again with the data line held low and watches the memory's return line until it reports ready or a poll limit runs out. Reads may stream several consecutive words in one chip-select window. Each word is offered on a valid/ready read port, and the serial clock stalls while a word waits to be taken. The serial clock rate, the minimum chip-select-low gap and the poll limit are all parameters.

The request port accepts a command only while `req_ready` is high, and that happens only when the controller is idle. A requester that holds `req_valid` simply waits. The read port applies back-pressure: `rd_valid` and `rd_data` stay fixed until `rd_ready` is seen. No further serial clocks are issued until then.

Top module: `sereep_host`

## Requirements
- R1: Every command frame is FRAME_LEN (16) serial clocks. It carries FRAME_LEN-3-ADDR_W leading zeros (7 with a 6-bit address), then a 1 start bit, a 2-bit opcode and the address, MSB first. Write and fill frames append 16 data bits MSB first, for 32 clocks in total.
- R2: The opcodes are read = 10, write = 01 and erase = 11. Fill-all, clear-all, enable and disable use opcode 00. The two top address bits then carry 01, 10, 11 and 00 respectively, and the remaining address bits are sent as 0.
- R3: The data out of the host changes only while the serial clock is low (it is updated at the falling edge). The return line is sampled at the rising edge. The serial clock stays low whenever chip select is low.
- R4: Chip select is low for at least CS_GAP system clock cycles before every rising edge of chip select.
- R5: A read discards the first return sample after the address and captures the next 16 as the word. A request with count N returns N+1 words from consecutive addresses, wrapping from the last address to 0, all within one chip-select-high window.
- R6: `rd_valid` and `rd_data` stay unchanged until `rd_ready` is high at a clock edge. No serial clock pulse occurs while `rd_valid` is high.
- R7: After a program frame, chip select falls, stays low for the gap, then rises with the data line held low. The request completes with `timed_out` = 0 as soon as the return line is seen high.
- R8: If the return line stays low for POLL_LIMIT cycles of polling, the request completes with `timed_out` = 1.
- R9: After reset the controller considers the memory write-protected. A program request while protected is preceded by an enable frame, which clears the flag. A disable request sets the flag again. An enable request clears it. No enable frame is sent while the flag is clear.
- R10: `req_ready` is high only when idle, and a request is taken when `req_valid` and `req_ready` are both high. The `req_op` codes are 0 read, 1 write, 2 erase, 3 fill-all, 4 clear-all, 5 enable and 6 disable. `done` pulses for exactly one cycle at the end of every request. After reset all pins are low, `req_ready` is 1 and `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Command request valid |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| req_op | input | 3 | Operation code (R10) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Data for write or fill-all |
| req_count | input | CNT_W | Extra words for a sequential read |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Read word taken |
| rd_data | output | DATA_W | Read word |
| done | output | 1 | One-cycle end-of-request pulse |
| timed_out | output | 1 | Last program poll ran out, valid with done |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data and ready status from the memory |

## Verification
The bench attaches a behavioural memory model that decodes every frame from the pins. A design that miscounts the leading zero bits, swaps opcode or sub-code bits, or puts a short frame on a write is caught by the model: it flags the frame length or zero count, or it writes the wrong word, and a later read exposes that. Reads cross the top address and wrap to zero, and read words are held back for up to two cycles. A controller that keeps the dummy sample shifts every word by one bit, and one that keeps clocking under back-pressure loses or alters a held word. The bench counts chip-select windows per request, so a missing or surplus enable frame shows up. A memory that never becomes ready must end the request with the timeout flag after at least the poll limit.

// File: rtl/sereep_pkg.sv
package sereep_pkg;
  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_ERASE = 3'd2,
    OP_WRALL = 3'd3,
    OP_ERALL = 3'd4,
    OP_WEN   = 3'd5,
    OP_WDS   = 3'd6
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_GAP, S_FRAME, S_RDW, S_RDH, S_PGAP, S_POLL, S_FIN
  } st_e;

  function automatic logic is_prog(op_e op);
    return (op == OP_WRITE) || (op == OP_ERASE) || (op == OP_WRALL) || (op == OP_ERALL);
  endfunction
endpackage

// File: rtl/sereep_wait.sv
module sereep_wait #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!run) cnt <= '0;
    else if (cnt != CW'(LIMIT - 1)) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/sereep_shift.sv
module sereep_shift #(
  parameter int DIV   = 2,
  parameter int VEC_W = 32,
  parameter int RX_W  = 16,
  parameter int NB_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NB_W-1:0]  nbits,
  input  logic [VEC_W-1:0] tx,
  input  logic             sdi,
  output logic             busy,
  output logic             done,
  output logic             sk,
  output logic             sdo,
  output logic [RX_W-1:0]  rx
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [VEC_W-1:0] vec;
  logic [NB_W-1:0]  left;
  logic [DW-1:0]    dc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec <= '0; left <= '0; dc <= '0; busy <= 1'b0; done <= 1'b0; sk <= 1'b0; rx <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        vec <= tx; left <= nbits; busy <= 1'b1; sk <= 1'b0; dc <= '0;
      end else if (busy) begin
        if (dc == DW'(DIV - 1)) begin
          dc <= '0;
          if (!sk) begin
            sk <= 1'b1;
            rx <= {rx[RX_W-2:0], sdi};
          end else begin
            sk   <= 1'b0;
            vec  <= vec << 1;
            left <= left - 1'b1;
            if (left == NB_W'(1)) begin
              busy <= 1'b0;
              done <= 1'b1;
            end
          end
        end else begin
          dc <= dc + 1'b1;
        end
      end
    end
  end

  assign sdo = busy & vec[VEC_W-1];

  // R3
  di_stable_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sk && $past(sk)) |-> $stable(sdo));
  // R3
  sk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sk);
endmodule

// File: rtl/sereep_host.sv
module sereep_host
  import sereep_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int FRAME_LEN  = 16,
  parameter int SK_DIV     = 2,
  parameter int CS_GAP     = 4,
  parameter int POLL_LIMIT = 500000,
  parameter int CNT_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CNT_W-1:0]  req_count,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              timed_out,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);
  localparam int PAD   = FRAME_LEN - 3 - ADDR_W;
  localparam int VEC_W = FRAME_LEN + DATA_W;
  localparam int NB_W  = $clog2(VEC_W + 1);

  st_e st;
  op_e cur_op, sv_op;
  logic wp, pend, tmo;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic [CNT_W-1:0]  left;
  logic sh_start, sh_busy, sh_done, gap_exp, poll_exp;
  logic [NB_W-1:0]   sh_nbits;
  logic [VEC_W-1:0]  sh_tx;
  logic [DATA_W-1:0] sh_rx;

  function automatic logic [VEC_W-1:0] mk_frame(op_e op, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    logic [1:0] opc;
    logic [ADDR_W-1:0] af;
    af = a;
    case (op)
      OP_READ:  opc = 2'b10;
      OP_WRITE: opc = 2'b01;
      OP_ERASE: opc = 2'b11;
      default: begin
        opc = 2'b00;
        af  = '0;
        case (op)
          OP_WRALL: af[ADDR_W-1 -: 2] = 2'b01;
          OP_ERALL: af[ADDR_W-1 -: 2] = 2'b10;
          OP_WEN:   af[ADDR_W-1 -: 2] = 2'b11;
          default:  af[ADDR_W-1 -: 2] = 2'b00;
        endcase
      end
    endcase
    return {{PAD{1'b0}}, 1'b1, opc, af, ((op == OP_WRITE) || (op == OP_WRALL)) ? d : {DATA_W{1'b0}}};
  endfunction

  sereep_shift #(.DIV(SK_DIV), .VEC_W(VEC_W), .RX_W(DATA_W), .NB_W(NB_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .nbits(sh_nbits), .tx(sh_tx), .sdi(ee_do),
    .busy(sh_busy), .done(sh_done), .sk(ee_sk), .sdo(ee_di), .rx(sh_rx)
  );

  sereep_wait #(.LIMIT(CS_GAP)) gap_i (
    .clk(clk), .rst_n(rst_n), .run((st == S_GAP) || (st == S_PGAP)), .expired(gap_exp)
  );

  sereep_wait #(.LIMIT(POLL_LIMIT)) poll_i (
    .clk(clk), .rst_n(rst_n), .run(st == S_POLL), .expired(poll_exp)
  );

  always_comb begin
    sh_start = 1'b0;
    sh_tx    = '0;
    sh_nbits = NB_W'(DATA_W);
    if (st == S_GAP) begin
      sh_start = gap_exp;
      sh_tx    = mk_frame(cur_op, addr, wdata);
      sh_nbits = ((cur_op == OP_WRITE) || (cur_op == OP_WRALL)) ? NB_W'(VEC_W) : NB_W'(FRAME_LEN);
    end else if (st == S_FRAME) begin
      sh_start = sh_done && (cur_op == OP_READ);
      sh_nbits = NB_W'(DATA_W + 1);
    end else if (st == S_RDH) begin
      sh_start = rd_ready && (left != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cur_op <= OP_READ; sv_op <= OP_READ; wp <= 1'b1; pend <= 1'b0; tmo <= 1'b0;
      addr <= '0; wdata <= '0; left <= '0; rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          sv_op <= op_e'(req_op);
          addr  <= req_addr;
          wdata <= req_wdata;
          left  <= req_count;
          tmo   <= 1'b0;
          if (is_prog(op_e'(req_op)) && wp) begin
            cur_op <= OP_WEN;
            pend   <= 1'b1;
          end else begin
            cur_op <= op_e'(req_op);
          end
          st <= S_GAP;
        end
        S_GAP: if (gap_exp) st <= S_FRAME;
        S_FRAME: if (sh_done) begin
          if (cur_op == OP_WEN) begin
            wp <= 1'b0;
            if (pend) begin
              pend <= 1'b0; cur_op <= sv_op; st <= S_GAP;
            end else st <= S_FIN;
          end else if (cur_op == OP_WDS) begin
            wp <= 1'b1; st <= S_FIN;
          end else if (cur_op == OP_READ) st <= S_RDW;
          else st <= S_PGAP;
        end
        S_RDW: if (sh_done) begin
          rd_valid <= 1'b1; rd_data <= sh_rx; st <= S_RDH;
        end
        S_RDH: if (rd_ready) begin
          rd_valid <= 1'b0;
          if (left == '0) st <= S_FIN;
          else begin
            left <= left - 1'b1; st <= S_RDW;
          end
        end
        S_PGAP: if (gap_exp) st <= S_POLL;
        S_POLL: if (ee_do) st <= S_FIN;
          else if (poll_exp) begin
            tmo <= 1'b1; st <= S_FIN;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign done      = (st == S_FIN);
  assign timed_out = tmo;
  assign ee_cs     = (st == S_FRAME) || (st == S_RDW) || (st == S_RDH) || (st == S_POLL);

  logic [$clog2(CS_GAP + 1)-1:0] low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= ($clog2(CS_GAP + 1))'(CS_GAP);
    else if (ee_cs) low_cnt <= '0;
    else if (low_cnt != ($clog2(CS_GAP + 1))'(CS_GAP)) low_cnt <= low_cnt + 1'b1;
  end

  // R4
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_cs && !$past(ee_cs)) |-> (low_cnt == ($clog2(CS_GAP + 1))'(CS_GAP)));
  // R3
  sk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs |-> !ee_sk);
  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  // R6
  rd_pause_sk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!ee_sk && !sh_busy));
  // R7
  poll_di_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_POLL) |-> (!ee_di && !ee_sk));
  // R10
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ee_cs && !sh_busy && !rd_valid));
endmodule

// File: tb/sereep_host_tb.sv
module sereep_host_tb_top;
  localparam int SK_DIV = 2, CS_GAP = 4, POLL_LIMIT = 300, BUSY = 120;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, rd_ready = 1'b0;
  logic [2:0] req_op = '0;
  logic [5:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_count = '0;
  logic req_ready, rd_valid, done, timed_out, cs, sk, di, do_line;
  logic [15:0] rd_data;

  always #10 clk = ~clk;

  sereep_host #(.SK_DIV(SK_DIV), .CS_GAP(CS_GAP), .POLL_LIMIT(POLL_LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_count(req_count), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .done(done), .timed_out(timed_out),
    .ee_cs(cs), .ee_sk(sk), .ee_di(di), .ee_do(do_line)
  );

  int tests = 0, fails = 0;
  longint cyc = 0, busy_until = 0;
  int zero_bad = 0, len_bad = 0, di_bad = 0, gap_bad = 0, stab_bad = 0;
  int cs_rises = 0, done_cnt = 0, lowc = 100, bp = 0, wc = 0, rn = 0;
  logic last_to = 1'b0, cs_c = 1'b0, hold_v = 1'b0, stuck = 1'b0;
  logic [15:0] hold_d = '0;
  logic [15:0] rbuf [0:15];

  // memory model
  logic [15:0] mem [0:63];
  logic cs_q = 1'b0, sk_q = 1'b0, started = 1'b0, reading = 1'b0, drv = 1'b0, verify = 1'b0, wen_m = 1'b0;
  int zeros = 0, nbit = 0, rises = 0, obit = 0;
  logic [31:0] sh = '0;
  logic [1:0] mop = '0;
  logic [5:0] maddr = '0;
  logic [15:0] obuf = '0;

  assign do_line = cs ? ((verify && !started) ? (cyc >= busy_until) : drv) : 1'b0;

  always @(cs or sk) begin
    if (cs !== cs_q) begin
      cs_q = cs;
      if (cs) begin
        started = 0; zeros = 0; nbit = 0; rises = 0; reading = 0; drv = 0;
      end else begin
        logic prog, wide;
        prog = 0; wide = 0;
        if (started && !reading) begin
          wide = (mop == 2'b01) || (mop == 2'b00 && maddr[5:4] == 2'b01);
          if (rises != (wide ? 32 : 16)) len_bad++;
          if (mop == 2'b01 && nbit == 24) begin
            prog = 1; if (wen_m) mem[maddr] = sh[15:0];
          end else if (mop == 2'b11 && nbit == 8) begin
            prog = 1; if (wen_m) mem[maddr] = 16'hFFFF;
          end else if (mop == 2'b00 && maddr[5:4] == 2'b01 && nbit == 24) begin
            prog = 1; if (wen_m) for (int i = 0; i < 64; i++) mem[i] = sh[15:0];
          end else if (mop == 2'b00 && maddr[5:4] == 2'b10 && nbit == 8) begin
            prog = 1; if (wen_m) for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
          end
        end
        verify = prog;
        if (prog) busy_until = stuck ? cyc + 64'd1000000000 : (wen_m ? cyc + BUSY : cyc);
      end
    end else if (sk && !sk_q && cs) begin
      rises++;
      if (reading) begin
        drv = obuf[15]; obuf = obuf << 1; obit++;
        if (obit == 16) begin maddr = maddr + 1'b1; obuf = mem[maddr]; obit = 0; end
      end else if (!started) begin
        if (di) begin started = 1; if (zeros != 7) zero_bad++; end
        else zeros++;
      end else begin
        sh = {sh[30:0], di}; nbit++;
        if (nbit == 8) begin
          mop = sh[7:6]; maddr = sh[5:0];
          if (mop == 2'b10) begin reading = 1; drv = 0; obuf = mem[maddr]; obit = 0; end
          else if (mop == 2'b00 && maddr[5:4] == 2'b11) wen_m = 1;
          else if (mop == 2'b00 && maddr[5:4] == 2'b00) wen_m = 0;
        end
      end
    end
    sk_q = sk;
  end

  always @(di) if (cs && sk) di_bad++;

  always @(posedge clk) begin
    cyc++;
    if (cs) begin
      if (!cs_c) begin cs_rises++; if (lowc < CS_GAP) gap_bad++; end
      lowc = 0;
    end else lowc++;
    cs_c = cs;
    if (done) begin done_cnt++; last_to = timed_out; end
    if (rd_valid && rd_ready) begin if (rn < 16) rbuf[rn] = rd_data; rn++; end
    if (rd_valid && !rd_ready) begin
      if (hold_v && rd_data !== hold_d) stab_bad++;
      hold_v = 1; hold_d = rd_data;
    end else hold_v = 0;
    if (rd_valid && sk) stab_bad++;
  end

  always @(negedge clk) begin
    if (rd_valid && !rd_ready) begin
      if (wc >= bp) rd_ready = 1; else wc++;
    end else begin rd_ready = 0; wc = 0; end
  end

  function automatic logic [15:0] pat(int a);
    return 16'((a * 1031) ^ 16'h5A5A);
  endfunction

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  int frames;
  longint dur;
  task automatic run_req(input int op, input int a, input int d, input int cnt);
    int d0, f0;
    longint t0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    d0 = done_cnt; f0 = cs_rises; rn = 0;
    req_valid = 1; req_op = 3'(op); req_addr = 6'(a); req_wdata = 16'(d); req_count = 2'(cnt);
    @(negedge clk);
    req_valid = 0; t0 = cyc;
    while (done_cnt == d0) @(negedge clk);
    frames = cs_rises - f0; dur = cyc - t0;
  endtask

  task automatic read_chk(input int a, input int cnt, input int stall, input logic fixed, input int val, input string tag);
    bp = stall;
    run_req(0, a, 0, cnt);
    chk(frames == 1, {tag, " R5 single cs window"}, frames, 1);
    chk(rn == cnt + 1, {tag, " R5 word count"}, rn, cnt + 1);
    for (int i = 0; i <= cnt; i++) begin
      logic [15:0] e;
      e = fixed ? 16'(val) : pat((a + i) % 64);
      chk(rbuf[i] == e, {tag, " R5 word"}, rbuf[i], e);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog R10", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!cs && !sk && !di, "R10 reset pins low", {cs, sk, di}, 0);
    chk(req_ready == 1'b1, "R10 reset ready", req_ready, 1);
    chk(!rd_valid && !done, "R10 reset idle outputs", {rd_valid, done}, 0);

    // first write: enable preamble (R9), completes ready (R7)
    run_req(1, 0, pat(0), 0);
    chk(frames == 3, "R9 enable preamble frames", frames, 3);
    chk(last_to == 1'b0, "R7 write completes ready", last_to, 0);
    chk(mem[0] == pat(0), "R1 R2 write frame decode", mem[0], pat(0));
    for (int a = 1; a < 64; a++) begin
      run_req(1, a, pat(a), 0);
      chk(frames == 2, "R9 no preamble when open", frames, 2);
      chk(mem[a] == pat(a), "R2 write lands", mem[a], pat(a));
    end
    chk(dur >= BUSY, "R7 waits for ready", dur, BUSY);

    // sequential read sweep with back-pressure (R5, R6)
    for (int b = 0; b < 64; b += 4) read_chk(b, 3, b % 3, 1'b0, 0, "sweep");
    read_chk(62, 3, 2, 1'b0, 0, "wrap");

    // erase one word (R2)
    run_req(2, 9, 0, 0);
    chk(frames == 2, "R7 erase frames", frames, 2);
    read_chk(9, 0, 0, 1'b1, 16'hFFFF, "R2 erase");
    read_chk(10, 0, 1, 1'b0, 0, "R2 neighbour");

    // protection on again, then program (R9)
    run_req(6, 0, 0, 0);
    chk(frames == 1, "R9 disable single frame", frames, 1);
    run_req(1, 9, 16'h1357, 0);
    chk(frames == 3, "R9 preamble after disable", frames, 3);
    read_chk(9, 0, 0, 1'b1, 16'h1357, "R9 write after reenable");
    run_req(6, 0, 0, 0);
    run_req(5, 0, 0, 0);
    chk(frames == 1, "R9 explicit enable frame", frames, 1);
    run_req(2, 4, 0, 0);
    chk(frames == 2, "R9 enable clears flag", frames, 2);

    // fill and clear all (R2)
    run_req(3, 0, 16'hC0DE, 0);
    read_chk(20, 3, 1, 1'b1, 16'hC0DE, "R2 fill all");
    run_req(4, 0, 0, 0);
    read_chk(0, 3, 0, 1'b1, 16'hFFFF, "R2 clear all");

    // stuck busy -> timeout (R8)
    stuck = 1;
    run_req(2, 3, 0, 0);
    chk(last_to == 1'b1, "R8 timeout flag", last_to, 1);
    chk(dur >= POLL_LIMIT, "R8 timeout duration", dur, POLL_LIMIT);
    stuck = 0;
    run_req(1, 5, 16'hBEEF, 0);
    chk(last_to == 1'b0, "R8 flag clears on next", last_to, 0);
    read_chk(5, 0, 0, 1'b1, 16'hBEEF, "R7 after timeout");

    chk(zero_bad == 0, "R1 leading zeros", zero_bad, 0);
    chk(len_bad == 0, "R1 frame length", len_bad, 0);
    chk(di_bad == 0, "R3 data stable while clock high", di_bad, 0);
    chk(gap_bad == 0, "R4 chip select gap", gap_bad, 0);
    chk(stab_bad == 0, "R6 held word stable and clock paused", stab_bad, 0);
    finish_run();
  end
endmodule